// File: doc/BRIEF.md
# Cut-Through Class-Buffered Router Input Port

This block sits at one input port of a packet router and gives every traffic class its own virtual channel. Flits arrive on a valid/ready stream tagged with a class number and with head and tail flags. When the class is already granted toward the output and its channel holds nothing, a flit goes straight through in the same cycle. When a head flit finds no grant, that packet and every later flit of its class are absorbed into the class's buffer. They leave once the downstream arbiter grants the class. Each channel holds two packets of the maximum length. The upstream router reserves space for a full packet before it sends, and counts that space in flits.

The block shows downstream arbitration which classes have a packet head waiting. It takes a per-class grant vector. A grant is sampled only between packets. Once the head flit of a packet leaves, the rest of that packet follows without flits of another class between them. When a tail flit leaves, the block returns credits upstream: a one-cycle pulse that carries the class and the packet's length in flits. Route computation and crossbar arbitration are done elsewhere.

Back-pressure rules: `in_ready` is low only when the flit's own class buffer is full and the flit cannot leave this cycle. `out_valid` may depend on `in_valid` in the same cycle, because of the cut-through path. Once a flit is offered with `out_ready` low, it stays on the output until it is taken, as long as the grants stay unchanged.

Top module: `ctvc_input_buffer`

## Requirements
- R1: While reset is held, `out_valid`, `cr_valid` and `vc_req` are all zero and `in_ready` is one.
- R2: A flit of class k arrives while class k is selected and buffer k is empty. It appears on the output in the same cycle with its data unchanged, and `in_ready` is high.
- R3: Each class buffer holds 2 x 19 = 38 flits. With 38 flits stored for class k, a class-k flit that cannot leave is refused (`in_ready` low).
- R4: `vc_req[k]` is high when a head flit is at the front of buffer k, or is arriving for an empty buffer k. It is held low for the class whose packet is leaving.
- R5: A grant is taken only when no packet is in progress. If several grant bits are set, the lowest class index wins. A change of grant in the middle of a packet has no effect on that packet.
- R6: After a head flit leaves, every flit on the output belongs to the same class until that packet's tail flit leaves.
- R7: Within one class, flits leave in arrival order with data, head and tail unchanged, and no flit is lost.
- R8: While `out_valid` is high and `out_ready` is low, the offered flit (class, flags, data) holds in the next cycle, provided the grants did not change.
- R9: One cycle after a tail flit leaves, `cr_valid` pulses for one cycle. `cr_cls` carries the packet's class and `cr_cnt` its number of flits. `cr_valid` is not raised at any other time.
- R10: A class whose buffer is full or blocked does not stop another class. Its flits are still accepted, and they still cut through when granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Incoming flit accepted |
| in_cls | input | CLS_W (3) | Class / virtual channel of incoming flit |
| in_head | input | 1 | Incoming flit is the first of its packet |
| in_tail | input | 1 | Incoming flit is the last of its packet |
| in_data | input | DATA_W (32) | Incoming flit payload |
| vc_gnt | input | NUM_CLS (7) | Per-class grant from downstream arbitration |
| vc_req | output | NUM_CLS (7) | Per-class packet-head-waiting indication |
| out_valid | output | 1 | Outgoing flit valid |
| out_ready | input | 1 | Outgoing flit taken |
| out_cls | output | CLS_W (3) | Class of outgoing flit |
| out_head | output | 1 | Outgoing flit is a head |
| out_tail | output | 1 | Outgoing flit is a tail |
| out_data | output | DATA_W (32) | Outgoing flit payload |
| cr_valid | output | 1 | Credit return pulse |
| cr_cls | output | CLS_W (3) | Class whose slots were freed |
| cr_cnt | output | CNT_W (5) | Number of freed flit slots |

## Verification
Suppose a buffer pointer or an occupancy count drifts. The next flit of that class then comes out with the wrong data or flags, or refuses to come out. The per-class scoreboard catches this on the first transfer of that class. A lost or stale packet lock shows up on the very next output flit, either as a class switch before a tail or as a non-head flit offered between packets. A wrong flit counter gives a wrong `cr_cnt` one cycle after the tail. The full-buffer boundary is checked exactly at the 38th stored flit, and a bad full flag is visible there on `in_ready`.

// File: rtl/ctvc_pkg.sv
package ctvc_pkg;
  localparam int DEF_NUM_CLS     = 7;
  localparam int DEF_MAX_LEN     = 19;
  localparam int DEF_PKTS_PER_VC = 2;
  localparam int DEF_DATA_W      = 32;

  typedef enum logic {
    OUT_IDLE = 1'b0,
    OUT_SEND = 1'b1
  } out_state_e;
endpackage

// File: rtl/ctvc_fifo.sv
module ctvc_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
endmodule

// File: rtl/ctvc_out_ctrl.sv
module ctvc_out_ctrl
  import ctvc_pkg::*;
#(
  parameter int NUM_CLS = 7,
  parameter int CLS_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLS-1:0] gnt,
  input  logic               fire,
  input  logic               fire_tail,
  output logic               busy,
  output logic [CLS_W-1:0]   sel,
  output logic               sel_ok
);
  out_state_e       state;
  logic [CLS_W-1:0] cur;
  logic [CLS_W-1:0] enc;
  logic             any;

  // lowest-index grant wins
  always_comb begin
    enc = '0;
    any = 1'b0;
    for (int k = NUM_CLS - 1; k >= 0; k--) begin
      if (gnt[k]) begin
        enc = CLS_W'(k);
        any = 1'b1;
      end
    end
  end

  assign busy   = (state == OUT_SEND);
  assign sel    = busy ? cur : enc;
  assign sel_ok = busy | any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= OUT_IDLE;
      cur   <= '0;
    end else if (fire) begin
      if (fire_tail) begin
        state <= OUT_IDLE;
      end else if (!busy) begin
        state <= OUT_SEND;
        cur   <= sel;
      end
    end
  end
endmodule

// File: rtl/ctvc_credit.sv
module ctvc_credit #(
  parameter int CLS_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             fire_tail,
  input  logic [CLS_W-1:0] fire_cls,
  output logic             cr_valid,
  output logic [CLS_W-1:0] cr_cls,
  output logic [CNT_W-1:0] cr_cnt
);
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= '0;
      cr_valid <= 1'b0;
      cr_cls   <= '0;
      cr_cnt   <= '0;
    end else begin
      cr_valid <= fire & fire_tail;
      if (fire) begin
        if (fire_tail) begin
          cr_cls <= fire_cls;
          cr_cnt <= seen + CNT_W'(1);
          seen   <= '0;
        end else begin
          seen <= seen + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ctvc_input_buffer.sv
module ctvc_input_buffer #(
  parameter int NUM_CLS     = ctvc_pkg::DEF_NUM_CLS,
  parameter int MAX_LEN     = ctvc_pkg::DEF_MAX_LEN,
  parameter int PKTS_PER_VC = ctvc_pkg::DEF_PKTS_PER_VC,
  parameter int DATA_W      = ctvc_pkg::DEF_DATA_W,
  localparam int CLS_W      = $clog2(NUM_CLS),
  localparam int CNT_W      = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CLS_W-1:0]   in_cls,
  input  logic               in_head,
  input  logic               in_tail,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [NUM_CLS-1:0] vc_gnt,
  output logic [NUM_CLS-1:0] vc_req,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CLS_W-1:0]   out_cls,
  output logic               out_head,
  output logic               out_tail,
  output logic [DATA_W-1:0]  out_data,
  output logic               cr_valid,
  output logic [CLS_W-1:0]   cr_cls,
  output logic [CNT_W-1:0]   cr_cnt
);
  localparam int DEPTH = MAX_LEN * PKTS_PER_VC;
  localparam int FW    = DATA_W + 2;

  logic [FW-1:0]      in_flit;
  logic [FW-1:0]      fifo_q [NUM_CLS];
  logic [NUM_CLS-1:0] f_empty, f_full, f_wr, f_rd;

  logic               busy, sel_ok;
  logic [CLS_W-1:0]   sel;
  logic               sel_empty, in_full;
  logic [FW-1:0]      sel_front, out_flit;
  logic               byp, take_byp, fire;

  assign in_flit = {in_head, in_tail, in_data};

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_vc
    ctvc_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (f_wr[g]),
      .wr_data (in_flit),
      .rd_en   (f_rd[g]),
      .rd_data (fifo_q[g]),
      .empty   (f_empty[g]),
      .full    (f_full[g])
    );
  end

  ctvc_out_ctrl #(.NUM_CLS(NUM_CLS), .CLS_W(CLS_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (vc_gnt),
    .fire      (fire),
    .fire_tail (out_tail),
    .busy      (busy),
    .sel       (sel),
    .sel_ok    (sel_ok)
  );

  ctvc_credit #(.CLS_W(CLS_W), .CNT_W(CNT_W)) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_tail (out_tail),
    .fire_cls  (sel),
    .cr_valid  (cr_valid),
    .cr_cls    (cr_cls),
    .cr_cnt    (cr_cnt)
  );

  // selected-class and incoming-class lookups
  always_comb begin
    sel_empty = 1'b1;
    sel_front = '0;
    in_full   = 1'b1;
    for (int k = 0; k < NUM_CLS; k++) begin
      if (sel == CLS_W'(k)) begin
        sel_empty = f_empty[k];
        sel_front = fifo_q[k];
      end
      if (in_cls == CLS_W'(k)) in_full = f_full[k];
    end
  end

  // cut-through when the granted class has nothing queued
  assign byp       = sel_ok & in_valid & (in_cls == sel) & sel_empty;
  assign out_valid = sel_ok & (~sel_empty | byp);
  assign out_flit  = sel_empty ? in_flit : sel_front;
  assign fire      = out_valid & out_ready;
  assign take_byp  = byp & out_ready;
  assign in_ready  = take_byp | ~in_full;

  assign out_cls  = sel;
  assign out_head = out_flit[FW-1];
  assign out_tail = out_flit[FW-2];
  assign out_data = out_flit[DATA_W-1:0];

  always_comb begin
    for (int k = 0; k < NUM_CLS; k++) begin
      f_wr[k]   = in_valid & in_ready & ~take_byp & (in_cls == CLS_W'(k));
      f_rd[k]   = fire & ~sel_empty & (sel == CLS_W'(k));
      vc_req[k] = ~(busy & (sel == CLS_W'(k))) &
                  (f_empty[k] ? (in_valid & in_head & (in_cls == CLS_W'(k)))
                              : fifo_q[k][FW-1]);
    end
  end
endmodule

// File: rtl/ctvc_checker.sv
module ctvc_checker #(
  parameter int NUM_CLS = 7,
  parameter int MAX_LEN = 19,
  parameter int DATA_W  = 32,
  localparam int CLS_W  = $clog2(NUM_CLS),
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [CLS_W-1:0]   in_cls,
  input logic [NUM_CLS-1:0] vc_gnt,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CLS_W-1:0]   out_cls,
  input logic               out_head,
  input logic               out_tail,
  input logic [DATA_W-1:0]  out_data,
  input logic               cr_valid,
  input logic [CNT_W-1:0]   cr_cnt
);
  logic             in_pkt;
  logic [CLS_W-1:0] pkt_cls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt  <= 1'b0;
      pkt_cls <= '0;
    end else if (out_valid && out_ready) begin
      in_pkt <= !out_tail;
      if (!in_pkt) pkt_cls <= out_cls;
    end
  end

  assert_class_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> in_cls < CLS_W'(NUM_CLS));

  assert_grant_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_pkt |-> out_head && vc_gnt[out_cls]);

  assert_no_interleave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_pkt |-> out_cls == pkt_cls && !out_head);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      (out_valid && $stable(out_data) && $stable(out_cls) && $stable(out_head) && $stable(out_tail))
      || (!in_pkt && !$stable(vc_gnt)));

  assert_credit_after_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_tail |=> cr_valid);

  assert_credit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> cr_cnt != '0 && cr_cnt <= CNT_W'(MAX_LEN));
endmodule

bind ctvc_input_buffer ctvc_checker #(
  .NUM_CLS (NUM_CLS),
  .MAX_LEN (MAX_LEN),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_cls    (in_cls),
  .vc_gnt    (vc_gnt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_cls   (out_cls),
  .out_head  (out_head),
  .out_tail  (out_tail),
  .out_data  (out_data),
  .cr_valid  (cr_valid),
  .cr_cnt    (cr_cnt)
);

// File: tb/sim_ctvc_input_buffer.sv
module sim_ctvc_input_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_head, in_tail, out_ready;
  logic        in_ready, out_valid, out_head, out_tail, cr_valid;
  logic [2:0]  in_cls, out_cls, cr_cls;
  logic [31:0] in_data, out_data;
  logic [6:0]  vc_gnt, vc_req;
  logic [4:0]  cr_cnt;

  always #5 clk = ~clk;

  ctvc_input_buffer u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls),
    .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
    .vc_gnt(vc_gnt), .vc_req(vc_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_cls(out_cls),
    .out_head(out_head), .out_tail(out_tail), .out_data(out_data),
    .cr_valid(cr_valid), .cr_cls(cr_cls), .cr_cnt(cr_cnt)
  );

  int n_tests = 0;
  int n_fail  = 0;
  // scoreboard item: {cls[2:0], len[4:0], head, tail, data[31:0]}
  logic [41:0] exp_q[$];
  int          done_cls[$];
  bit          mon_pkt = 0;
  int          mon_cls = 0;
  bit          cr_pend = 0;
  int          pend_cls = 0;
  int          pend_cnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic sync();
    @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(input int cls, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      bit acc;
      in_valid = 1'b1;
      in_cls   = cls[2:0];
      in_head  = (i == 0);
      in_tail  = (i == len - 1);
      in_data  = base + i;
      exp_q.push_back({cls[2:0], len[4:0], in_head, in_tail, in_data});
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        acc = in_ready;
        @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
  endtask

  // monitor: per-class ordered scoreboard, interleave and credit checks
  always @(negedge clk) begin
    int found;
    logic [41:0] e;
    if (rst_n) begin
      if (cr_pend) begin
        chk(cr_valid && cr_cls == pend_cls[2:0], "R9 credit class", cr_cls, pend_cls);
        chk(cr_valid && cr_cnt == pend_cnt[4:0], "R9 credit count", cr_cnt, pend_cnt);
        cr_pend = 0;
      end else if (cr_valid) begin
        chk(1'b0, "R9 spurious credit", cr_cnt, 0);
      end
      if (out_valid && out_ready) begin
        found = -1;
        for (int i = 0; i < exp_q.size(); i++) begin
          if (exp_q[i][41:39] == out_cls) begin
            found = i;
            break;
          end
        end
        if (found < 0) begin
          chk(1'b0, "R7 unexpected flit", out_data, 0);
        end else begin
          e = exp_q[found];
          exp_q.delete(found);
          chk({out_head, out_tail, out_data} == e[33:0], "R7 flit content/order",
              {out_head, out_tail, out_data}, e[33:0]);
          if (out_tail) begin
            cr_pend  = 1;
            pend_cls = out_cls;
            pend_cnt = e[38:34];
            done_cls.push_back(int'(out_cls));
          end
        end
        if (mon_pkt) chk(out_cls == mon_cls[2:0], "R6 class switch inside packet", out_cls, mon_cls);
        mon_pkt = !out_tail;
        mon_cls = out_cls;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    summary();
    $finish;
  end

  initial begin
    in_valid = 0; in_head = 0; in_tail = 0; in_cls = 0; in_data = 0;
    out_ready = 0; vc_gnt = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(cr_valid == 0, "R1 cr_valid in reset", cr_valid, 0);
    chk(vc_req == 0, "R1 vc_req in reset", vc_req, 0);
    chk(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    sync();
    rst_n = 1;
    sync();

    // R2: cut-through on a granted empty class
    vc_gnt = 7'b0000100;
    out_ready = 1;
    fork
      send_pkt(2, 3, 32'h100);
      begin
        @(negedge clk);
        chk(out_valid && out_cls == 2 && out_data == 32'h100 && in_ready,
            "R2 same-cycle pass", out_data, 32'h100);
      end
    join
    repeat (3) sync();

    // R4/R5/R6: blocked packets, lowest grant, mid-packet grant change
    vc_gnt = 0;
    send_pkt(1, 3, 32'h200);
    send_pkt(4, 2, 32'h300);
    @(negedge clk);
    chk(vc_req == 7'b0010010, "R4 heads waiting", vc_req, 7'b0010010);
    sync();
    vc_gnt = 7'b0010010;
    @(negedge clk);
    chk(out_valid && out_cls == 1, "R5 lowest grant wins", out_cls, 1);
    sync();
    vc_gnt = 7'b0010000;
    @(negedge clk);
    chk(vc_req[1] == 0 && vc_req[4] == 1, "R4 sending class masked", vc_req, 7'b0010000);
    repeat (8) sync();
    chk(done_cls.size() >= 2 && done_cls[done_cls.size()-2] == 1 && done_cls[$] == 4,
        "R5 grant change ignored mid-packet", done_cls[$], 4);

    // R8: stall holds the offered flit
    vc_gnt = 7'b0001000;
    out_ready = 0;
    fork
      send_pkt(3, 2, 32'h400);
      begin
        @(negedge clk);
        chk(out_valid && out_data == 32'h400, "R8 offered under stall", out_data, 32'h400);
        @(negedge clk);
        chk(out_valid && out_head && out_data == 32'h400, "R8 held next cycle", out_data, 32'h400);
        @(posedge clk);
        #1;
        out_ready = 1;
      end
    join
    repeat (4) sync();

    // R3/R10: fill class 5 to 38 flits, other class still accepted
    vc_gnt = 0;
    send_pkt(5, 19, 32'h500);
    send_pkt(5, 19, 32'h600);
    in_valid = 1; in_cls = 5; in_head = 1; in_tail = 1; in_data = 32'h700;
    @(negedge clk);
    chk(in_ready == 0, "R3 full class refuses", in_ready, 0);
    sync();
    in_cls = 6; in_data = 32'h800;
    exp_q.push_back({3'd6, 5'd1, 1'b1, 1'b1, 32'h800});
    @(negedge clk);
    chk(in_ready == 1, "R10 other class accepted while one is full", in_ready, 1);
    sync();
    in_valid = 0;
    @(negedge clk);
    chk(vc_req == 7'b1100000, "R4 heads of classes 5 and 6", vc_req, 7'b1100000);
    sync();
    vc_gnt = 7'b0100000;
    repeat (42) sync();
    chk(done_cls[$] == 5, "R7 full class drained", done_cls[$], 5);
    vc_gnt = 7'b1000000;
    repeat (3) sync();
    chk(done_cls[$] == 6, "R10 other class delivered", done_cls[$], 6);

    // R10: class 0 blocked, class 2 still cuts through
    vc_gnt = 0;
    send_pkt(0, 2, 32'h900);
    vc_gnt = 7'b0000100;
    fork
      send_pkt(2, 3, 32'hA00);
      begin
        @(negedge clk);
        chk(out_valid && out_cls == 2 && out_data == 32'hA00,
            "R10 bypass beside blocked class", out_data, 32'hA00);
      end
    join
    repeat (3) sync();
    chk(done_cls[$] == 2, "R10 granted class finished first", done_cls[$], 2);
    vc_gnt = 7'b0000001;
    repeat (4) sync();
    chk(done_cls[$] == 0, "R7 blocked class drained later", done_cls[$], 0);

    chk(exp_q.size() == 0, "R7 every flit delivered", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule